// File: doc/BRIEF.md
# Stator Flux and Torque Estimator

This block is the estimation front end of a direct-torque-control loop for an induction machine. Every sampling period a strobe delivers two signed phase-current samples and the three inverter leg states. The block turns them into d/q-axis currents and voltages, runs a leaky backward-Euler integrator per axis to track the stator flux, and from that flux computes the flux magnitude and the electromagnetic torque. The hysteresis comparators, sector logic and switching table that consume these results sit outside.

The work is split over two strobes. The first strobe computes the axis transforms and the flux update together. The next strobe takes those registered results and computes the magnitude, using an unsigned non-restoring square root, and the torque, using a cross product. All other arithmetic is signed fixed point. Each intermediate result is cut back to a chosen format instead of growing without bound.

Top module: `dtc_flux_torque_est`

## Requirements
- R1: A synchronous active-high reset clears both flux components, the magnitude, the torque and both valid outputs to zero. The first strobe after reset produces no magnitude/torque pulse.
- R2: `flux_vld_o` is high for exactly the one cycle after each clock edge that samples `smp_stb` high. Between strobes, `flux_d_o` and `flux_q_o` hold their values.
- R3: Currents are 21-bit two's complement with 16 fractional bits. The d current equals Ia. The q current is ((Ia + 2·Ib) · 151349) arithmetically shifted right by 18 and held in 22 bits, where 151349 is 1/√3 with 18 fractional bits.
- R4: With leg inputs `sw_a`, `sw_b`, `sw_c` (1 = upper switch on), Vd = KVD·(2a − b − c) and Vq = KVQ·(b − c). Here KVD = (VDC·2^16)/3 and KVQ = (VDC·151349)>>2, both with 16 fractional bits. With the default VDC=300 these are 6553600 and 11351175.
- R5: On each strobe, each flux axis (24 fractional bits) becomes f − (f>>>10) + ((671·e)>>>19). Here e = V − ((98304·I)>>>16), so Rs = 1.5 Ω with 16 fractional bits, and the sample period is 671/2^27 s.
- R6: On a strobe that is not the first after reset, `flux_mag_o` becomes floor(√(fd²+fq²)) of the flux values held before that strobe, in 24 fractional bits, and `est_vld_o` pulses for one cycle.
- R7: On the same strobe, `torque_o` becomes ((fd·Iq − fq·Id)·3·P)>>>25, truncated to 32 bits, where P = 2 pole pairs. Id, Iq, fd and fq are all held from the previous strobe.
- R8: `est_vld_o` is high only in the cycle after a strobe, and only once stage 1 holds a sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle sample strobe, once per sampling period |
| ia_i | input | 21 | Phase A current, signed, 16 fractional bits |
| ib_i | input | 21 | Phase B current, signed, 16 fractional bits |
| sw_a | input | 1 | Leg A upper switch state |
| sw_b | input | 1 | Leg B upper switch state |
| sw_c | input | 1 | Leg C upper switch state |
| flux_d_o | output | 31 | d-axis stator flux, signed, 24 fractional bits |
| flux_q_o | output | 31 | q-axis stator flux, signed, 24 fractional bits |
| flux_vld_o | output | 1 | Flux components updated |
| flux_mag_o | output | 31 | Flux magnitude, unsigned, 24 fractional bits |
| torque_o | output | 32 | Torque estimate, signed, 16 fractional bits |
| est_vld_o | output | 1 | Magnitude and torque updated |

## Verification
The flux components and `flux_vld_o` are due one clock after the edge that samples the strobe. The magnitude and torque for a sample are due one clock after the following strobe, so they trail the flux by one strobe interval. The bench raises the strobe on a falling edge and drops it on the next falling edge. At that second falling edge it compares every output against a reference model that keeps the previous sample's currents and flux. It then checks on each falling edge of the random gap before the next strobe that both valid lines are low and the flux holds.

// File: rtl/dtc_est_pkg.sv
`timescale 1ns/1ps
package dtc_est_pkg;
  // 1/sqrt(3) in unsigned 1.18 fixed point
  localparam int     INV_SQRT3_F = 18;
  localparam int     INV_SQRT3_W = 20;
  localparam longint INV_SQRT3_Q = 151349;
endpackage

// File: rtl/dtc_axis_xform.sv
`timescale 1ns/1ps
module dtc_axis_xform
  import dtc_est_pkg::*;
#(
  parameter int     CUR_W = 21,
  parameter int     ISC_W = 22,
  parameter int     V_W   = 28,
  parameter longint KVD   = 6553600,
  parameter longint KVQ   = 11351175
) (
  input  logic signed [CUR_W-1:0] ia,
  input  logic signed [CUR_W-1:0] ib,
  input  logic                    sa,
  input  logic                    sb,
  input  logic                    sc,
  output logic signed [ISC_W-1:0] id,
  output logic signed [ISC_W-1:0] iq,
  output logic signed [V_W-1:0]   vd,
  output logic signed [V_W-1:0]   vq
);
  localparam int SUM_W = CUR_W + 2;
  localparam int PRD_W = SUM_W + INV_SQRT3_W;
  localparam logic signed [INV_SQRT3_W-1:0] K_ISQ = INV_SQRT3_W'(INV_SQRT3_Q);
  localparam logic signed [V_W-1:0] KVD_S = V_W'(KVD);
  localparam logic signed [V_W-1:0] KVQ_S = V_W'(KVQ);

  logic signed [SUM_W-1:0] ib2, isum;
  logic signed [PRD_W-1:0] qprod;
  logic signed [3:0]       dsel, qsel;

  // 2*Ib held one bit wider so the sum with Ia cannot wrap
  assign ib2   = SUM_W'(ib) <<< 1;
  assign isum  = SUM_W'(ia) + ib2;
  assign qprod = PRD_W'(isum) * PRD_W'(K_ISQ);
  assign iq    = ISC_W'(qprod >>> INV_SQRT3_F);
  assign id    = ISC_W'(ia);

  assign dsel = $signed({2'b00, sa, 1'b0}) - $signed({3'b000, sb}) - $signed({3'b000, sc});
  assign qsel = $signed({3'b000, sb}) - $signed({3'b000, sc});
  assign vd   = KVD_S * V_W'(dsel);
  assign vq   = KVQ_S * V_W'(qsel);
endmodule

// File: rtl/dtc_flux_axis.sv
`timescale 1ns/1ps
module dtc_flux_axis #(
  parameter int     ISC_W   = 22,
  parameter int     V_W     = 28,
  parameter int     FLX_W   = 31,
  parameter int     CUR_F   = 16,
  parameter int     FLX_F   = 24,
  parameter int     TS_F    = 27,
  parameter longint RS_Q    = 98304,
  parameter longint TS_Q    = 671,
  parameter int     LEAK_SH = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ISC_W-1:0] cur,
  input  logic signed [V_W-1:0]   volt,
  output logic signed [FLX_W-1:0] flx
);
  localparam int E_W    = V_W + 1;
  localparam int RS_W   = 20;
  localparam int TS_W   = TS_F + 1;
  localparam int RP_W   = ISC_W + RS_W;
  localparam int TP_W   = E_W + TS_W;
  localparam int TS_SH  = TS_F + CUR_F - FLX_F;
  localparam logic signed [RS_W-1:0] RS_S = RS_W'(RS_Q);
  localparam logic signed [TS_W-1:0] TS_S = TS_W'(TS_Q);

  logic signed [RP_W-1:0]  rprod;
  logic signed [E_W-1:0]   drop, emf;
  logic signed [TP_W-1:0]  tprod;
  logic signed [FLX_W-1:0] inc, leak, nxt;

  assign rprod = RP_W'(cur) * RP_W'(RS_S);
  assign drop  = E_W'(rprod >>> CUR_F);
  assign emf   = E_W'(volt) - drop;
  assign tprod = TP_W'(emf) * TP_W'(TS_S);
  assign inc   = FLX_W'(tprod >>> TS_SH);
  assign leak  = flx >>> LEAK_SH;
  assign nxt   = flx - leak + inc;

  always_ff @(posedge clk) begin
    if (rst)     flx <= '0;
    else if (en) flx <= nxt;
  end
endmodule

// File: rtl/dtc_isqrt_nr.sv
`timescale 1ns/1ps
module dtc_isqrt_nr #(
  parameter int RAD_W = 62
) (
  input  logic [RAD_W-1:0]   rad,
  output logic [RAD_W/2-1:0] root
);
  localparam int HALF = RAD_W / 2;
  localparam int RW   = HALF + 2;

  logic signed [RW-1:0] rem [HALF+1];
  logic [HALF-1:0]      q   [HALF+1];

  assign rem[0] = '0;
  assign q[0]   = '0;

  for (genvar k = 0; k < HALF; k++) begin : g_step
    logic signed [RW-1:0] shifted;
    assign shifted  = {rem[k][RW-3:0], rad[2*(HALF-1-k) +: 2]};
    // negative remainder: add back, otherwise subtract trial
    assign rem[k+1] = rem[k][RW-1] ? (shifted + $signed({q[k], 2'b11}))
                                   : (shifted - $signed({q[k], 2'b01}));
    assign q[k+1]   = {q[k][HALF-2:0], ~rem[k+1][RW-1]};
  end

  assign root = q[HALF];
endmodule

// File: rtl/dtc_flux_torque_est.sv
`timescale 1ns/1ps
module dtc_flux_torque_est
  import dtc_est_pkg::*;
#(
  parameter int CUR_W      = 21,
  parameter int CUR_F      = 16,
  parameter int FLX_W      = 31,
  parameter int FLX_F      = 24,
  parameter int TQ_W       = 32,
  parameter int VDC        = 300,
  parameter int RS_Q       = 98304,
  parameter int TS_Q       = 671,
  parameter int TS_F       = 27,
  parameter int LEAK_SH    = 10,
  parameter int POLE_PAIRS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_stb,
  input  logic signed [CUR_W-1:0] ia_i,
  input  logic signed [CUR_W-1:0] ib_i,
  input  logic                    sw_a,
  input  logic                    sw_b,
  input  logic                    sw_c,
  output logic signed [FLX_W-1:0] flux_d_o,
  output logic signed [FLX_W-1:0] flux_q_o,
  output logic                    flux_vld_o,
  output logic [FLX_W-1:0]        flux_mag_o,
  output logic signed [TQ_W-1:0]  torque_o,
  output logic                    est_vld_o
);
  localparam int     ISC_W  = CUR_W + 1;
  localparam int     V_W    = $clog2(VDC) + CUR_F + 3;
  localparam int     RAD_W  = 2 * FLX_W;
  localparam int     PX_W   = FLX_W + ISC_W + 1;
  localparam int     KT_W   = 8;
  localparam int     SC_W   = PX_W + KT_W;
  localparam int     TQ_SH  = 1 + FLX_F;
  localparam longint KVD    = (longint'(VDC) << CUR_F) / 3;
  localparam longint KVQ    = (longint'(VDC) * INV_SQRT3_Q) >>> (INV_SQRT3_F - CUR_F);
  localparam logic signed [KT_W-1:0] KTQ = KT_W'(3 * POLE_PAIRS);

  // ---------------- stage 1: transforms and flux integration
  logic signed [ISC_W-1:0] id_w, iq_w, id_s1, iq_s1;
  logic signed [V_W-1:0]   vd_w, vq_w;
  logic signed [ISC_W-1:0] ax_i [2];
  logic signed [V_W-1:0]   ax_v [2];
  logic signed [FLX_W-1:0] ax_f [2];
  logic                    s1_full;

  dtc_axis_xform #(
    .CUR_W(CUR_W), .ISC_W(ISC_W), .V_W(V_W), .KVD(KVD), .KVQ(KVQ)
  ) u_xform (
    .ia(ia_i), .ib(ib_i), .sa(sw_a), .sb(sw_b), .sc(sw_c),
    .id(id_w), .iq(iq_w), .vd(vd_w), .vq(vq_w)
  );

  assign ax_i[0] = id_w;
  assign ax_i[1] = iq_w;
  assign ax_v[0] = vd_w;
  assign ax_v[1] = vq_w;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    dtc_flux_axis #(
      .ISC_W(ISC_W), .V_W(V_W), .FLX_W(FLX_W), .CUR_F(CUR_F), .FLX_F(FLX_F),
      .TS_F(TS_F), .RS_Q(longint'(RS_Q)), .TS_Q(longint'(TS_Q)), .LEAK_SH(LEAK_SH)
    ) u_int (
      .clk(clk), .rst(rst), .en(smp_stb),
      .cur(ax_i[g]), .volt(ax_v[g]), .flx(ax_f[g])
    );
  end

  assign flux_d_o = ax_f[0];
  assign flux_q_o = ax_f[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      id_s1      <= '0;
      iq_s1      <= '0;
      s1_full    <= 1'b0;
      flux_vld_o <= 1'b0;
    end else begin
      flux_vld_o <= smp_stb;
      if (smp_stb) begin
        id_s1   <= id_w;
        iq_s1   <= iq_w;
        s1_full <= 1'b1;
      end
    end
  end

  // ---------------- stage 2: magnitude and torque
  logic [RAD_W-1:0]        rad_w;
  logic [FLX_W-1:0]        root_w;
  logic signed [PX_W-1:0]  cross_w;
  logic signed [SC_W-1:0]  scaled_w;
  logic signed [TQ_W-1:0]  tq_w;

  assign rad_w = RAD_W'(flux_d_o * flux_d_o) + RAD_W'(flux_q_o * flux_q_o);

  dtc_isqrt_nr #(.RAD_W(RAD_W)) u_sqrt (.rad(rad_w), .root(root_w));

  assign cross_w  = PX_W'(flux_d_o) * PX_W'(iq_s1) - PX_W'(flux_q_o) * PX_W'(id_s1);
  assign scaled_w = SC_W'(cross_w) * SC_W'(KTQ);
  assign tq_w     = TQ_W'(scaled_w >>> TQ_SH);

  always_ff @(posedge clk) begin
    if (rst) begin
      flux_mag_o <= '0;
      torque_o   <= '0;
      est_vld_o  <= 1'b0;
    end else begin
      est_vld_o <= smp_stb & s1_full;
      if (smp_stb && s1_full) begin
        flux_mag_o <= root_w;
        torque_o   <= tq_w;
      end
    end
  end

  // ---------------- assertions
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!flux_vld_o && !est_vld_o && flux_d_o == '0 && flux_q_o == '0));

  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> flux_vld_o);

  a_r2_vld_only_after_stb: assert property (@(posedge clk) disable iff (rst)
    flux_vld_o |-> $past(smp_stb));

  a_r2_flux_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(smp_stb) |-> ($stable(flux_d_o) && $stable(flux_q_o)));

  a_r8_est_after_stb: assert property (@(posedge clk) disable iff (rst)
    est_vld_o |-> $past(smp_stb));

  a_r6_root_floor: assert property (@(posedge clk) disable iff (rst)
    est_vld_o |-> ((64'(flux_mag_o) * 64'(flux_mag_o) <= 64'($past(rad_w))) &&
                   ((64'(flux_mag_o) + 64'd1) * (64'(flux_mag_o) + 64'd1) > 64'($past(rad_w)))));
endmodule

// File: tb/tb_dtc_flux_torque_est.sv
`timescale 1ns/1ps
module tb_dtc_flux_torque_est;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic signed [20:0] ia_i = '0, ib_i = '0;
  logic sw_a = 1'b0, sw_b = 1'b0, sw_c = 1'b0;
  logic signed [30:0] flux_d_o, flux_q_o;
  logic flux_vld_o, est_vld_o;
  logic [30:0] flux_mag_o;
  logic signed [31:0] torque_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  longint m_fd = 0, m_fq = 0, m_id = 0, m_iq = 0;
  bit m_full = 0;

  always #2.5 clk = ~clk;

  dtc_flux_torque_est dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .ia_i(ia_i), .ib_i(ib_i),
    .sw_a(sw_a), .sw_b(sw_b), .sw_c(sw_c),
    .flux_d_o(flux_d_o), .flux_q_o(flux_q_o), .flux_vld_o(flux_vld_o),
    .flux_mag_o(flux_mag_o), .torque_o(torque_o), .est_vld_o(est_vld_o)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint isqrt(input longint rad);
    longint r = 0;
    for (int b = 30; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= rad) r = t;
    end
    return r;
  endfunction

  function automatic longint flux_step(input longint f, input longint v, input longint i);
    longint e = v - ((98304 * i) >>> 16);
    return f - (f >>> 10) + ((671 * e) >>> 19);
  endfunction

  function automatic longint torque_ref(input longint fd, input longint fq,
                                        input longint id, input longint iq);
    longint c = (fd * iq - fq * id) * 6;
    longint t = c >>> 25;
    return longint'(int'(t));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    smp_stb = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 flux_d", longint'(flux_d_o), 0);
    chk("R1 flux_q", longint'(flux_q_o), 0);
    chk("R1 mag", longint'(flux_mag_o), 0);
    chk("R1 torque", longint'(torque_o), 0);
    chk("R1 vld", longint'({flux_vld_o, est_vld_o}), 0);
    rst = 1'b0;
    m_fd = 0; m_fq = 0; m_id = 0; m_iq = 0; m_full = 0;
  endtask

  task automatic do_sample(input logic signed [20:0] a, input logic signed [20:0] b,
                           input logic sa, input logic sb, input logic sc, input int gap);
    longint id, iq, vd, vq, nfd, nfq, emag, etq;
    @(negedge clk);
    ia_i = a; ib_i = b; sw_a = sa; sw_b = sb; sw_c = sc;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    id = longint'(a);
    iq = ((longint'(a) + 2 * longint'(b)) * 151349) >>> 18;
    vd = 6553600 * (2 * longint'(sa) - longint'(sb) - longint'(sc));
    vq = 11351175 * (longint'(sb) - longint'(sc));
    nfd = flux_step(m_fd, vd, id);
    nfq = flux_step(m_fq, vq, iq);
    emag = isqrt(m_fd * m_fd + m_fq * m_fq);
    etq = torque_ref(m_fd, m_fq, m_id, m_iq);
    chk("R2 flux_vld pulse", longint'(flux_vld_o), 1);
    chk("R4 R5 flux_d", longint'(flux_d_o), nfd);
    chk("R3 R4 R5 flux_q", longint'(flux_q_o), nfq);
    chk("R8 est_vld", longint'(est_vld_o), longint'(m_full));
    if (m_full) begin
      chk("R6 magnitude", longint'(flux_mag_o), emag);
      chk("R3 R7 torque", longint'(torque_o), etq);
    end
    m_fd = nfd; m_fq = nfq; m_id = id; m_iq = iq; m_full = 1;
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      chk("R2 flux_vld low between strobes", longint'(flux_vld_o), 0);
      chk("R8 est_vld low between strobes", longint'(est_vld_o), 0);
      chk("R2 flux_d hold", longint'(flux_d_o), m_fd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    do_reset();
    // directed corners
    do_sample(21'sd0, 21'sd0, 1'b0, 1'b0, 1'b0, 2);
    do_sample(21'sd65536, 21'sd0, 1'b1, 1'b0, 1'b0, 3);
    do_sample(21'sd1048575, 21'sd1048575, 1'b1, 1'b1, 1'b0, 2);
    do_sample(-21'sd1048576, -21'sd1048576, 1'b0, 1'b1, 1'b1, 2);
    do_sample(21'sd1048575, -21'sd1048576, 1'b1, 1'b1, 1'b1, 4);
    do_sample(-21'sd1048576, 21'sd1048575, 1'b0, 1'b0, 1'b1, 2);
    // random run
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      do_sample(21'($urandom), 21'($urandom), r[0], r[1], r[2], 1 + int'(r[5:3]));
    end
    // steady excitation to grow flux
    for (int n = 0; n < 200; n++)
      do_sample(21'sd300000, -21'sd150000, 1'b1, 1'b0, 1'b0, 1);
    // mid-run reset: pipeline empties again
    do_reset();
    do_sample(21'sd200000, 21'sd100000, 1'b0, 1'b1, 1'b0, 2);
    do_sample(21'sd200000, 21'sd100000, 1'b0, 1'b1, 1'b0, 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule